// File: doc/BRIEF.md
# Open-Page Bank Hit Tracker

This block records which row is open in each internal bank of an SDRAM controller that serves two chip-select regions, each with four banks. It holds eight entries, one per (chip-select, bank) pair, so pages can stay open in several banks of both regions at the same time. The command sequencer reports the commands it issues: row activate, precharge of one bank, precharge of every bank in a region, and auto-refresh. The block updates its entries from these reports.

For each request, given the decoded chip-select, bank and row, the block reports one of three outcomes. A hit means the bank has this row open. A miss means the bank has a different row open and needs a precharge before an activate. Idle means the bank has no open row. The lookup is combinational on the stored state, so the sequencer gets the outcome in the same cycle it presents the request.

Top module: `open_page_tracker`

## Requirements
- R1: While `rst` is high at a rising clock edge, every entry is closed. Once `rst` is low, every lookup reports idle until a row is activated.
- R2: A command with `cmd_code` = 1 (activate) opens row `cmd_row` in the entry selected by `cmd_cs` and `cmd_bank`. From the next cycle, a lookup of that chip-select, bank and row reports hit.
- R3: A lookup of an open entry with a row that differs from the stored row reports miss.
- R4: In every cycle exactly one of `hit`, `miss` and `idle` is high.
- R5: `cmd_code` = 2 (single-bank precharge) closes only the entry selected by `cmd_cs` and `cmd_bank`. All other entries keep their state.
- R6: `cmd_code` = 3 (precharge all) closes all four entries of chip-select `cmd_cs`. Entries of the other chip-select are unchanged.
- R7: `cmd_code` = 4 (auto-refresh) closes all four entries of chip-select `cmd_cs`, the same way as R6. Entries of the other chip-select are unchanged.
- R8: The lookup result follows the request inputs in the same cycle. A command presented in a cycle changes lookups only from the following cycle.
- R9: `cmd_code` values 0, 5, 6 and 7 change no entry.
- R10: All eight entries hold rows independently. A new activate on an already open entry replaces its stored row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cs | input | CS_W (1) | Chip-select of the request being looked up |
| req_bank | input | BANK_W (2) | Bank of the request |
| req_row | input | ROW_W (13) | Row of the request |
| cmd_code | input | 3 | Command report: 0 none, 1 activate, 2 precharge one bank, 3 precharge all, 4 auto-refresh |
| cmd_cs | input | CS_W (1) | Chip-select the command targets |
| cmd_bank | input | BANK_W (2) | Bank the command targets (used by codes 1 and 2) |
| cmd_row | input | ROW_W (13) | Row opened by an activate |
| hit | output | 1 | Request row is open in its bank |
| miss | output | 1 | A different row is open in the request's bank |
| idle | output | 1 | Request's bank has no open row |

## Verification
The assertions check on every cycle that the three outcome flags are mutually exclusive and complete. They also check that an activate leaves its entry open and that any precharge closes its target, and that a region-wide precharge or refresh leaves no open entry in that region. They further check that unknown codes leave all entries untouched and that reset closes everything. Only the bench's scenarios show that a hit needs the exact stored row, that the other seven entries survive a command aimed elsewhere, and that a row replacement takes effect. The same-cycle order of lookup and update is also shown only by the bench.

// File: rtl/obt_pkg.sv
`timescale 1ns/1ps
package obt_pkg;

    // Command report codes from the sequencer
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ACTIVATE = 3'd1,
        OP_PRE_ONE  = 3'd2,
        OP_PRE_CS   = 3'd3,
        OP_REFRESH  = 3'd4
    } op_e;

    // Lookup outcome, one-hot
    typedef struct packed {
        logic hit;
        logic miss;
        logic idle;
    } lookup_t;

    function automatic lookup_t classify(input logic open_q, input logic same_row);
        lookup_t r;
        r.hit  = open_q & same_row;
        r.miss = open_q & ~same_row;
        r.idle = ~open_q;
        return r;
    endfunction

    function automatic logic op_known(input logic [2:0] code);
        return (code == OP_ACTIVATE) || (code == OP_PRE_ONE) ||
               (code == OP_PRE_CS)   || (code == OP_REFRESH);
    endfunction

    function automatic logic op_closes_region(input logic [2:0] code);
        return (code == OP_PRE_CS) || (code == OP_REFRESH);
    endfunction

endpackage

// File: rtl/obt_entry.sv
`timescale 1ns/1ps
module obt_entry #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             clear,
    input  logic [ROW_W-1:0] load_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic             open_o,
    output logic             match_o
);

    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (load) begin
            open_q <= 1'b1;
        end else if (clear) begin
            open_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            row_q <= load_row;
        end
    end

    assign open_o  = open_q;
    assign match_o = (row_q == probe_row);

    // R2: an activate leaves the entry open
    assert_load_opens_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> open_o);

    // R5: a precharge aimed at this entry closes it
    assert_clear_closes_R5: assert property (@(posedge clk) disable iff (rst)
        (clear && !load) |=> !open_o);

    // R10: an entry not addressed keeps its open state
    assert_untouched_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!clear && !load) |=> $stable(open_o));

endmodule

// File: rtl/obt_lookup.sv
`timescale 1ns/1ps
module obt_lookup
    import obt_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] open_vec,
    input  logic [ENTRIES-1:0] match_vec,
    input  logic [IDX_W-1:0]   idx,
    output lookup_t            result
);

    always_comb begin
        result = classify(open_vec[idx], match_vec[idx]);
    end

endmodule

// File: rtl/open_page_tracker.sv
`timescale 1ns/1ps
module open_page_tracker
    import obt_pkg::*;
#(
    parameter int NUM_CS    = 2,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [2:0]        cmd_code,
    input  logic [CS_W-1:0]   cmd_cs,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    output logic              hit,
    output logic              miss,
    output logic              idle
);

    localparam int ENTRIES = NUM_CS * NUM_BANKS;
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] open_vec;
    logic [ENTRIES-1:0] match_vec;
    logic [NUM_CS-1:0]  cs_any_open;
    logic [IDX_W-1:0]   req_idx;
    lookup_t            res;

    assign req_idx = IDX_W'(int'(req_cs) * NUM_BANKS + int'(req_bank));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        localparam int G_CS = g / NUM_BANKS;
        localparam int G_BK = g % NUM_BANKS;
        logic cs_sel, bk_sel, ld, clr;

        assign cs_sel = (int'(cmd_cs) == G_CS);
        assign bk_sel = (int'(cmd_bank) == G_BK);
        assign ld     = (cmd_code == OP_ACTIVATE) && cs_sel && bk_sel;
        assign clr    = ((cmd_code == OP_PRE_ONE) && cs_sel && bk_sel) ||
                        (op_closes_region(cmd_code) && cs_sel);

        obt_entry #(.ROW_W(ROW_W)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .load      (ld),
            .clear     (clr),
            .load_row  (cmd_row),
            .probe_row (req_row),
            .open_o    (open_vec[g]),
            .match_o   (match_vec[g])
        );
    end

    for (genvar c = 0; c < NUM_CS; c++) begin : g_region
        assign cs_any_open[c] = |open_vec[c*NUM_BANKS +: NUM_BANKS];
    end

    obt_lookup #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lookup (
        .open_vec  (open_vec),
        .match_vec (match_vec),
        .idx       (req_idx),
        .result    (res)
    );

    assign hit  = res.hit;
    assign miss = res.miss;
    assign idle = res.idle;

    // R1: reset closes every entry
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (open_vec == '0));

    // R4: exactly one outcome flag
    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (rst)
        $countones({hit, miss, idle}) == 1);

    // R6 / R7: region-wide close leaves nothing open in that region
    assert_region_closed_R6_R7: assert property (@(posedge clk) disable iff (rst)
        op_closes_region(cmd_code) |=> !cs_any_open[$past(cmd_cs)]);

    // R9: unknown codes change no entry
    assert_unknown_noop_R9: assert property (@(posedge clk) disable iff (rst)
        !op_known(cmd_code) |=> $stable(open_vec));

endmodule

// File: tb/open_page_tracker_tb.sv
`timescale 1ns/1ps
module open_page_tracker_tb;

    localparam int NUM_CS = 2;
    localparam int NUM_BANKS = 4;
    localparam int ROW_W = 13;
    localparam int ENT = NUM_CS * NUM_BANKS;
    localparam int MASK = (1 << ROW_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [0:0] req_cs = '0;
    logic [1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [2:0] cmd_code = '0;
    logic [0:0] cmd_cs = '0;
    logic [1:0] cmd_bank = '0;
    logic [ROW_W-1:0] cmd_row = '0;
    logic hit, miss, idle;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    bit m_open [ENT];
    int m_row  [ENT];

    always #2.5 clk = ~clk;

    open_page_tracker #(.NUM_CS(NUM_CS), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_dut (
        .clk(clk), .rst(rst),
        .req_cs(req_cs), .req_bank(req_bank), .req_row(req_row),
        .cmd_code(cmd_code), .cmd_cs(cmd_cs), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .hit(hit), .miss(miss), .idle(idle)
    );

    // 0 idle, 1 hit, 2 miss
    function automatic int model_exp(int e, int row);
        if (!m_open[e]) return 0;
        return (m_row[e] == row) ? 1 : 2;
    endfunction

    function automatic int got_code();
        if (hit && !miss && !idle) return 1;
        if (miss && !hit && !idle) return 2;
        if (idle && !hit && !miss) return 0;
        return 3;
    endfunction

    task automatic probe(int cs, int bk, int row, int exp, string tag);
        int got;
        req_cs = cs[0:0]; req_bank = bk[1:0]; req_row = row[ROW_W-1:0];
        #0.2;
        got = got_code();
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s cs=%0d bank=%0d row=%0d actual=%0d expected=%0d",
                     tag, cs, bk, row, got, exp);
        end
        checks++;
        if (int'(hit) + int'(miss) + int'(idle) != 1) begin
            failures++;
            $display("FAIL R4 flags actual=%b%b%b expected one-hot", hit, miss, idle);
        end
    endtask

    task automatic sweep(string tag);
        for (int e = 0; e < ENT; e++) begin
            int r;
            r = m_open[e] ? m_row[e] : (e * 113) & MASK;
            probe(e / NUM_BANKS, e % NUM_BANKS, r, model_exp(e, r), tag);
            probe(e / NUM_BANKS, e % NUM_BANKS, r ^ 1, model_exp(e, r ^ 1), tag);
            probe(e / NUM_BANKS, e % NUM_BANKS, r ^ (1 << (ROW_W-1)),
                  model_exp(e, r ^ (1 << (ROW_W-1))), tag);
        end
    endtask

    task automatic issue(int op, int cs, int bk, int row);
        @(negedge clk);
        cmd_code = op[2:0]; cmd_cs = cs[0:0]; cmd_bank = bk[1:0]; cmd_row = row[ROW_W-1:0];
        @(posedge clk);
        #0.5;
        cmd_code = 3'd0;
        case (op)
            1: begin m_open[cs*NUM_BANKS+bk] = 1; m_row[cs*NUM_BANKS+bk] = row & MASK; end
            2: m_open[cs*NUM_BANKS+bk] = 0;
            3, 4: for (int b = 0; b < NUM_BANKS; b++) m_open[cs*NUM_BANKS+b] = 0;
            default: ;
        endcase
    endtask

    function automatic int row_of(int e, int salt);
        return (e * 409 + salt * 977 + 77) & MASK;
    endfunction

    initial begin
        for (int e = 0; e < ENT; e++) begin m_open[e] = 0; m_row[e] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sweep("R1");

        // R2 / R3: open each entry in turn
        for (int e = 0; e < ENT; e++) begin
            issue(1, e / NUM_BANKS, e % NUM_BANKS, row_of(e, 0));
            sweep("R2_R3");
        end

        // R10: replace a row in an open entry
        issue(1, 1, 1, row_of(5, 3));
        sweep("R10");
        issue(1, 0, 3, 0);
        sweep("R10");

        // R9: unknown codes
        for (int op = 5; op < 8; op++) begin
            issue(op, op % 2, op % 4, 1234);
            sweep("R9");
        end
        issue(0, 1, 2, 99);
        sweep("R9");

        // R5: single-bank precharge
        issue(2, 0, 2, 0);
        sweep("R5");
        issue(2, 1, 0, 0);
        sweep("R5");

        // R6: precharge all of region 1
        issue(3, 1, 0, 0);
        sweep("R6");
        for (int b = 0; b < NUM_BANKS; b++) issue(1, 1, b, row_of(b, 7));
        sweep("R6");

        // R7: refresh region 0, then region 1
        issue(4, 0, 1, 0);
        sweep("R7");
        issue(4, 1, 3, 0);
        sweep("R7");

        // R8: command and lookup in the same cycle
        @(negedge clk);
        cmd_code = 3'd1; cmd_cs = 1'b0; cmd_bank = 2'd1; cmd_row = 13'h0ABC;
        probe(0, 1, 13'h0ABC, 0, "R8");
        @(posedge clk);
        #0.5;
        cmd_code = 3'd0;
        m_open[1] = 1; m_row[1] = 13'h0ABC;
        probe(0, 1, 13'h0ABC, 1, "R8");
        probe(0, 1, 13'h0ABD, 2, "R8");
        sweep("R8");

        // R1: reset again closes everything
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #0.5;
        rst = 1'b0;
        for (int e = 0; e < ENT; e++) m_open[e] = 0;
        sweep("R1");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule